// File: doc/BRIEF.md
# Sliding Window Multi Pattern Matcher

This block scans a packet byte stream, one byte per valid beat, for a fixed set of content strings. Each accepted byte is pushed into a shift chain. The chain is as long as the longest string in either of two built-in string sets. Every string of a set is compared in parallel against the newest bytes of the window. A string of length L is compared only against the L most recent bytes of the current packet. When any string of the active set is found, a registered match pulse is raised.

The two string sets share the single chain. A select input decides which set's comparators drive the result. Matching is relaxed to one content string per rule, so the block may report false positives but never misses a string that is present. At the end of each packet the block reports whether anything matched inside that packet. A downstream gate uses that flag to forward the packet for software analysis.

Top module: `wpm_top`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, `matchOut`, `pktDone` and `pktAlert` are all 0.
- R2: `matchOut` is 1 in the cycle after a valid beat exactly when, for some string of the active set, every one of its characters equals the corresponding byte among the most recent bytes of the current packet, with the beat's byte as the last character.
- R3: If any single character differs from the string, that string gives no match.
- R4: A string shorter than the window is aligned to the newest byte. It is found at any offset within a packet, and overlapping occurrences each raise their own pulse.
- R5: The window is as deep as the longest string across both sets. With the default parameters, the 8-byte string `%n%n%n%n` of set B is found.
- R6: `setSel` = 0 selects set A and `setSel` = 1 selects set B. The strings of the unselected set never cause a match or a packet alert.
- R7: A valid beat with `inSop` = 1 starts a new window, so a string split across two packets is not matched.
- R8: `pktDone` is 1 for one cycle after each beat with `inEop` = 1. In that same cycle `pktAlert` is the OR of all matches of that packet, including a match completed by the final byte. At all other times `pktAlert` is 0.
- R9: Cycles with `inValid` = 0 do not shift the window and produce no outputs, so a string delivered with idle gaps between its bytes is still found.
- R10: A one-byte packet, with `inSop` and `inEop` on the same beat, gives `pktDone` = 1. It matches only a string of length 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A byte is presented on this cycle |
| inByte | input | 8 | Stream byte |
| inSop | input | 1 | First byte of a packet |
| inEop | input | 1 | Last byte of a packet |
| setSel | input | 1 | Active string set: 0 = A, 1 = B |
| matchOut | output | 1 | Registered pulse: a string of the active set ended on the previous beat |
| pktAlert | output | 1 | Packet contained a match; valid with pktDone |
| pktDone | output | 1 | End-of-packet strobe, one cycle after the last beat |

## Verification
The assertions assume that `setSel` holds its value on every valid beat and changes only on idle cycles. They also assume that each packet starts with an `inSop` beat and that each configured string length lies between 1 and the pattern width. The stimulus changes the set only on cycles with `inValid` low, always frames packets with start and end markers, and keeps the default strings. Under these conditions the properties are checked: match and packet flags follow only valid beats, an alert is never reported without the end-of-packet strobe, and the window holds still while the input is idle.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic shiftEn;
    logic restart;
  } wpmStrobe_t;
endpackage

// File: rtl/wpm_bank.sv
module wpm_bank #(
  parameter int NUM_PAT = 4,
  parameter int MAX_LEN = 8,
  parameter int WIN_LEN = 8,
  parameter logic [NUM_PAT-1:0][MAX_LEN*8-1:0] PATS = '0,
  parameter logic [NUM_PAT-1:0][7:0] LENS = '0
) (
  input  logic [WIN_LEN-1:0][7:0] window,
  input  logic [WIN_LEN-1:0]      filled,
  output logic [NUM_PAT-1:0]      hits
);
  // window[0] is the newest byte; pattern byte k (bits 8k+7:8k) is its k-th newest character
  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic [WIN_LEN-1:0] posOk;
    always_comb begin
      for (int j = 0; j < WIN_LEN; j++) begin
        if (j >= int'(LENS[p])) posOk[j] = 1'b1;
        else posOk[j] = filled[j] && (window[j] == PATS[p][8*j +: 8]);
      end
    end
    assign hits[p] = &posOk;
  end
endmodule

// File: rtl/wpm_datapath.sv
module wpm_datapath
  import wpm_pkg::*;
#(
  parameter int NUM_PAT = 4,
  parameter int MAX_LEN = 8,
  parameter int CHAIN_LEN = 8,
  parameter logic [NUM_PAT-1:0][MAX_LEN*8-1:0] PAT_A = '0,
  parameter logic [NUM_PAT-1:0][7:0] LEN_A = '0,
  parameter logic [NUM_PAT-1:0][MAX_LEN*8-1:0] PAT_B = '0,
  parameter logic [NUM_PAT-1:0][7:0] LEN_B = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wpmStrobe_t        strb,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              setSel,
  output logic              anyHit
);
  logic [CHAIN_LEN-1:0][7:0] chainQ, nextWin;
  logic [CHAIN_LEN-1:0]      fillQ, nextFill;
  logic [NUM_PAT-1:0]        hitA, hitB;

  assign nextWin[0]  = inByte;
  assign nextFill[0] = 1'b1;
  for (genvar i = 1; i < CHAIN_LEN; i++) begin : g_shift
    assign nextWin[i]  = strb.restart ? 8'h00 : chainQ[i-1];
    assign nextFill[i] = strb.restart ? 1'b0  : fillQ[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chainQ <= '0;
      fillQ  <= '0;
    end else if (strb.shiftEn) begin
      chainQ <= nextWin;
      fillQ  <= nextFill;
    end
  end

  wpm_bank #(.NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN), .WIN_LEN(CHAIN_LEN),
             .PATS(PAT_A), .LENS(LEN_A)) bankA_i (
    .window(nextWin), .filled(nextFill), .hits(hitA));

  wpm_bank #(.NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN), .WIN_LEN(CHAIN_LEN),
             .PATS(PAT_B), .LENS(LEN_B)) bankB_i (
    .window(nextWin), .filled(nextFill), .hits(hitB));

  assign anyHit = strb.shiftEn && (setSel ? |hitB : |hitA);

  // R9: window frozen on idle cycles
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shiftEn |=> ($stable(chainQ) && $stable(fillQ)));

  // R7: after a packet start only the newest slot is occupied
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.shiftEn && strb.restart) |=> ($countones(fillQ) == 1 && fillQ[0]));
endmodule

// File: rtl/wpm_ctrl.sv
module wpm_ctrl
  import wpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inSop,
  input  logic       inEop,
  input  logic       setSel,
  input  logic       anyHit,
  output wpmStrobe_t strb,
  output logic       matchOut,
  output logic       pktAlert,
  output logic       pktDone
);
  logic accQ;

  assign strb.shiftEn = inValid;
  assign strb.restart = inValid && inSop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ     <= 1'b0;
      matchOut <= 1'b0;
      pktAlert <= 1'b0;
      pktDone  <= 1'b0;
    end else begin
      matchOut <= inValid && anyHit;
      pktDone  <= inValid && inEop;
      pktAlert <= inValid && inEop && (anyHit || (accQ && !inSop));
      if (inValid) accQ <= inEop ? 1'b0 : ((accQ && !inSop) || anyHit);
    end
  end

  // R6: select may only move on idle cycles
  a_r6_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> $stable(setSel));

  // R2 and R9: a match pulse always follows a valid beat
  a_r2_match_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    matchOut |-> $past(inValid));

  // R8: the packet strobe follows an end-of-packet beat
  a_r8_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    pktDone |-> $past(inValid && inEop));

  // R8: an alert is reported only with the strobe
  a_r8_alert_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pktAlert |-> pktDone);

  // R8: a match on the final byte must show in the alert
  a_r8_last_match_alerts: assert property (@(posedge clk) disable iff (!rst_n)
    (matchOut && pktDone) |-> pktAlert);
endmodule

// File: rtl/wpm_top.sv
module wpm_top
  import wpm_pkg::*;
#(
  parameter int NUM_PAT = 4,
  parameter int MAX_LEN = 8,
  parameter logic [NUM_PAT-1:0][MAX_LEN*8-1:0] PAT_A =
    {64'("XY"), 64'("passwd"), 64'("cmd.exe"), 64'("GET /")},
  parameter logic [NUM_PAT-1:0][7:0] LEN_A = {8'd2, 8'd6, 8'd7, 8'd5},
  parameter logic [NUM_PAT-1:0][MAX_LEN*8-1:0] PAT_B =
    {64'("%n%n%n%n"), 64'("EHLO mx"), 64'("root"), 64'("USER ")},
  parameter logic [NUM_PAT-1:0][7:0] LEN_B = {8'd8, 8'd7, 8'd4, 8'd5}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inSop,
  input  logic              inEop,
  input  logic              setSel,
  output logic              matchOut,
  output logic              pktAlert,
  output logic              pktDone
);
  function automatic int longest();
    int m = 1;
    for (int p = 0; p < NUM_PAT; p++) begin
      if (int'(LEN_A[p]) > m) m = int'(LEN_A[p]);
      if (int'(LEN_B[p]) > m) m = int'(LEN_B[p]);
    end
    return m;
  endfunction

  localparam int CHAIN_LEN = longest();

  wpmStrobe_t strb;
  logic       anyHit;

  wpm_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .setSel(setSel), .anyHit(anyHit), .strb(strb), .matchOut(matchOut),
    .pktAlert(pktAlert), .pktDone(pktDone));

  wpm_datapath #(.NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN), .CHAIN_LEN(CHAIN_LEN),
                 .PAT_A(PAT_A), .LEN_A(LEN_A), .PAT_B(PAT_B), .LEN_B(LEN_B)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inByte(inByte), .setSel(setSel),
    .anyHit(anyHit));
endmodule

// File: tb/wpm_top_tb.sv
module wpm_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic inSop = 1'b0, inEop = 1'b0, setSel = 1'b0;
  logic matchOut, pktAlert, pktDone;

  int checks = 0;
  int failures = 0;
  string reqTag = "R1";

  string setA[4] = '{"GET /", "cmd.exe", "passwd", "XY"};
  string setB[4] = '{"USER ", "root", "EHLO mx", "%n%n%n%n"};
  logic [7:0] pkt[$];
  bit acc = 1'b0;

  always #2.5 clk = ~clk;

  wpm_top dut_i (.clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte),
    .inSop(inSop), .inEop(inEop), .setSel(setSel), .matchOut(matchOut),
    .pktAlert(pktAlert), .pktDone(pktDone));

  function automatic bit modelHit(bit sel);
    bit found = 1'b0;
    for (int p = 0; p < 4; p++) begin
      string s = sel ? setB[p] : setA[p];
      int n = pkt.size();
      int L = s.len();
      bit ok = (n >= L);
      for (int i = 0; i < L && ok; i++)
        if (pkt[n - L + i] != s[i]) ok = 1'b0;
      if (ok) found = 1'b1;
    end
    return found;
  endfunction

  task automatic check(input bit em, input bit ed, input bit ea);
    checks++;
    if ({matchOut, pktDone, pktAlert} !== {em, ed, ea}) begin
      failures++;
      $display("FAIL %s: {match,done,alert} actual=%b%b%b expected=%b%b%b",
               reqTag, matchOut, pktDone, pktAlert, em, ed, ea);
    end
  endtask

  // called at a negedge; drives one cycle and checks the registered result
  task automatic step(input bit v, input logic [7:0] b, input bit sop, input bit eop);
    bit em = 1'b0, ed = 1'b0, ea = 1'b0;
    inValid = v; inByte = b; inSop = sop; inEop = eop;
    if (v) begin
      if (sop) begin pkt.delete(); acc = 1'b0; end
      pkt.push_back(b);
      em = modelHit(setSel);
      acc = acc | em;
      if (eop) begin ed = 1'b1; ea = acc; acc = 1'b0; end
    end
    @(posedge clk);
    @(negedge clk);
    check(em, ed, ea);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic sendPkt(input string s, input int gapAfter);
    for (int i = 0; i < s.len(); i++) begin
      step(1'b1, s[i], i == 0, i == s.len() - 1);
      if (gapAfter > 0 && i == gapAfter - 1) idle(2);
    end
  endtask

  task automatic selectSet(input bit sel);
    @(negedge clk);
    setSel = sel;
    idle(1);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    reqTag = "R1";
    repeat (3) @(negedge clk);
    check(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    idle(1);

    reqTag = "R2"; sendPkt("xxGET /yy", 0);
    reqTag = "R2"; sendPkt("cmd.exe", 0);
    reqTag = "R3"; sendPkt("GET -cmd.exf", 0);
    reqTag = "R3"; sendPkt("pa5swd", 0);
    reqTag = "R4"; sendPkt("XYXYX", 0);
    reqTag = "R4"; sendPkt("aaXY", 0);
    reqTag = "R7"; sendPkt("abpass", 0);
    reqTag = "R7"; sendPkt("wd", 0);
    reqTag = "R9"; sendPkt("zcmd.exe", 3);
    idle(3);
    reqTag = "R10"; sendPkt("X", 0);
    reqTag = "R10"; sendPkt("Y", 0);
    reqTag = "R6"; sendPkt("root USER %n%n%n%n", 0);

    selectSet(1'b1);
    reqTag = "R5"; sendPkt("zz%n%n%n%n", 0);
    reqTag = "R5"; sendPkt("%n%n%n%", 0);
    reqTag = "R6"; sendPkt("GET /passwdXY", 0);
    reqTag = "R6"; sendPkt("USER root", 0);
    reqTag = "R8"; sendPkt("EHLO mxq", 0);
    reqTag = "R8"; sendPkt("clean", 0);

    selectSet(1'b0);
    reqTag = "R8"; sendPkt("passwd", 0);
    idle(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule